// File: doc/BRIEF.md
# Multi-Set Event Counter Facility

A bank of free-running event counters split into four counter sets: basic, problem-state, crypto-activity and extended. Every counter advances by one on each clock where its event input is high and its set is counting. One control word sets two bits per set, an enable bit and an activation bit. These bits place the set in one of three states. A disabled set holds all its counters at zero. An inactive set (enabled, not activated) freezes them. An active set counts.

An authorization mask decides which sets may be enabled. A control write that tries to enable a set outside the mask is dropped whole. When the mask withdraws a set that is enabled, the block shuts that set down, which loses its data, and it raises an alert. A separate alert pulses on any change of the mask. Software reads a counter by its number through a one-cycle read port. Each read returns the count, an invalid-number code, or a not-available code. Counters never raise overflow interrupts; they wrap silently.

Top module: `evt_ctr_facility`

## Requirements
- R1: Control word layout: enable bits at [19:16] and activation bits at [3:0]. Within each nibble, bit 0 is the extended set, bit 1 basic, bit 2 problem-state and bit 3 crypto. An accepted write shows on `ctl_word_o` after the next rising edge. All other bits of `ctl_word_o` read zero.
- R2: A set whose enable bit is clear has all its counters at zero. The clear happens at the same edge the set becomes disabled. A read of a valid number in a disabled set returns error code 2 (not available).
- R3: A set that is enabled but not activated holds every counter value unchanged.
- R4: In an active set, a counter increments by one on each cycle its event bit is high. It wraps modulo 2^CTR_W and has no other effect.
- R5: Problem-state counters (numbers 32-37) count only while `user_mode_i` is high. Basic counters (0-5) count in either mode.
- R6: Counter numbers 6-31, 38-63 and 80-127 are reserved. A read of one returns error code 1 (invalid).
- R7: The limit for numbers 64 and up is set by `set_ver_i`. Version 0: every number at or above 64 is invalid. Version 1: 64-79 and 128-159 are valid. Version 2: the limit is 175. Version 3 and later: the limit is 255. Valid extended numbers at or above 128+EXT_N read zero.
- R8: A control write whose enable field includes a set missing from `auth_i` is rejected, and the previous control word is kept.
- R9: If `auth_i` lacks a set that is currently enabled, that set's enable and activation bits are cleared and its counters are zeroed at the next edge. `alert_lost_o` pulses for one cycle after that edge.
- R10: `alert_auth_o` pulses for one cycle after any edge where `auth_i` differs from its value at the previous edge. The stored value is zero after reset.
- R11: A read request gives `rd_valid_o` one cycle later, with the counter value as it stood before the request edge. Invalid has priority over not-available. Data is zero on any error. With no request, valid, error and data are zero.
- R12: After reset the control word, the alerts, the read outputs and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_mode_i | input | 1 | High while the processor runs in user mode |
| ev_basic_i | input | 6 | Event inputs, counters 0-5 |
| ev_user_i | input | 6 | Event inputs, counters 32-37 |
| ev_crypto_i | input | 16 | Event inputs, counters 64-79 |
| ev_ext_i | input | EXT_N | Event inputs, counters 128 upward |
| auth_i | input | 4 | Authorization mask, same bit order as R1 |
| set_ver_i | input | 4 | Crypto/extended set version |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word write data |
| ctl_word_o | output | 32 | Current control word |
| rd_req_i | input | 1 | Counter read request |
| rd_num_i | input | 8 | Counter number to read |
| rd_valid_o | output | 1 | Read response valid |
| rd_err_o | output | 2 | 0 ok, 1 invalid number, 2 not available |
| rd_data_o | output | CTR_W | Counter value |
| alert_auth_o | output | 1 | Authorization change alert |
| alert_lost_o | output | 1 | Counter data lost alert |

## Verification
The assertions assume that all inputs carry known values after reset and change only between clock edges. They also assume the authorization mask is a plain level, so any difference between two edges counts as a change. The stimulus drives every input on the falling edge. It holds the mask and version steady for many cycles, then changes them in single steps that cover withdrawal of an enabled set and a rejected write under a reduced mask. Version values are swept while the same numbers are read, so each limit is hit from both sides.

// File: rtl/efc_pkg.sv
package efc_pkg;
    localparam int NSETS    = 4;
    localparam int EN_LSB   = 16;
    localparam int ACT_LSB  = 0;
    localparam int BASIC_N  = 6;
    localparam int USER_N   = 6;
    localparam int CRYPTO_N = 16;
    localparam int BASIC_IW  = $clog2(BASIC_N);
    localparam int USER_IW   = $clog2(USER_N);
    localparam int CRYPTO_IW = $clog2(CRYPTO_N);

    // set index equals bit position in the control nibbles
    typedef enum logic [1:0] {
        SET_EXT    = 2'd0,
        SET_BASIC  = 2'd1,
        SET_USER   = 2'd2,
        SET_CRYPTO = 2'd3
    } set_e;

    typedef enum logic [1:0] {
        RD_OK      = 2'd0,
        RD_INVALID = 2'd1,
        RD_UNAVAIL = 2'd2
    } rd_err_e;

    typedef struct packed {
        logic [NSETS-1:0] en;
        logic [NSETS-1:0] act;
        logic [NSETS-1:0] auth;
        logic             alert_auth;
        logic             alert_lost;
    } ctrl_st_t;

    function automatic logic [7:0] upper_limit(input logic [3:0] ver);
        if (ver == 4'd1)      return 8'd159;
        else if (ver == 4'd2) return 8'd175;
        else                  return 8'd255;
    endfunction
endpackage

// File: rtl/efc_ctrl.sv
module efc_ctrl
    import efc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSETS-1:0] auth_i,
    input  logic             wr_i,
    input  logic [NSETS-1:0] wr_en_bits_i,
    input  logic [NSETS-1:0] wr_act_bits_i,
    output logic [NSETS-1:0] en_q_o,
    output logic [NSETS-1:0] act_q_o,
    output logic [NSETS-1:0] en_d_o,
    output logic             alert_auth_o,
    output logic             alert_lost_o
);
    ctrl_st_t ctl_d, ctl_q;
    logic [NSETS-1:0] unauth;
    logic             accept;

    always_comb begin
        unauth = ~auth_i;
        accept = wr_i && ((wr_en_bits_i & unauth) == '0);
        ctl_d  = ctl_q;
        if (accept) begin
            ctl_d.en  = wr_en_bits_i;
            ctl_d.act = wr_act_bits_i;
        end
        ctl_d.en         = ctl_d.en & auth_i;
        ctl_d.act        = ctl_d.act & auth_i;
        ctl_d.auth       = auth_i;
        ctl_d.alert_auth = (auth_i != ctl_q.auth);
        ctl_d.alert_lost = |(ctl_q.en & unauth);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign en_q_o       = ctl_q.en;
    assign act_q_o      = ctl_q.act;
    assign en_d_o       = ctl_d.en;
    assign alert_auth_o = ctl_q.alert_auth;
    assign alert_lost_o = ctl_q.alert_lost;

    // R8
    reject_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && ((wr_en_bits_i & ~auth_i) != '0) && ((ctl_q.en & ~auth_i) == '0)
              && ((ctl_q.act & ~auth_i) == '0))
        |=> ($stable(en_q_o) && $stable(act_q_o)));

    // R9
    auth_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q_o & ~$past(auth_i)) == '0));

    // R9
    lost_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q_o & ~auth_i) != '0) |=> alert_lost_o);

    // R10
    auth_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(auth_i) |=> alert_auth_o);
endmodule

// File: rtl/efc_set_bank.sv
module efc_set_bank #(
    parameter int N = 6,
    parameter int W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                keep_i,
    input  logic                run_i,
    input  logic [N-1:0]        ev_i,
    output logic [N-1:0][W-1:0] cnt_o
);
    logic [N-1:0][W-1:0] cnt_d, cnt_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            if (!keep_i)
                cnt_d[i] = '0;
            else if (run_i && ev_i[i])
                cnt_d[i] = cnt_q[i] + W'(1);
            else
                cnt_d[i] = cnt_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R2
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !keep_i |=> (cnt_o == '0));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_i && !run_i) |=> $stable(cnt_o));

    for (genvar g = 0; g < N; g++) begin : g_step
        // R4
        step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (keep_i && run_i && ev_i[g]) |=> (cnt_o[g] == $past(cnt_o[g]) + W'(1)));
    end
endmodule

// File: rtl/efc_num_decode.sv
module efc_num_decode
    import efc_pkg::*;
#(
    parameter int EXT_N = 48
) (
    input  logic [7:0] num_i,
    input  logic [3:0] ver_i,
    output logic       valid_o,
    output set_e       set_o,
    output logic [7:0] idx_o,
    output logic       impl_o
);
    localparam logic [7:0] USER_BASE   = 8'd32;
    localparam logic [7:0] CRYPTO_BASE = 8'd64;
    localparam logic [7:0] EXT_BASE    = 8'd128;

    logic [7:0] lim;

    always_comb begin
        lim     = upper_limit(ver_i);
        valid_o = 1'b0;
        set_o   = SET_BASIC;
        idx_o   = '0;
        impl_o  = 1'b0;
        if (num_i < 8'(BASIC_N)) begin
            valid_o = 1'b1;
            idx_o   = num_i;
            impl_o  = 1'b1;
        end else if (num_i >= USER_BASE && num_i < USER_BASE + 8'(USER_N)) begin
            valid_o = 1'b1;
            set_o   = SET_USER;
            idx_o   = num_i - USER_BASE;
            impl_o  = 1'b1;
        end else if (num_i >= CRYPTO_BASE && num_i < CRYPTO_BASE + 8'(CRYPTO_N)) begin
            valid_o = (ver_i != 4'd0);
            set_o   = SET_CRYPTO;
            idx_o   = num_i - CRYPTO_BASE;
            impl_o  = 1'b1;
        end else if (num_i >= EXT_BASE) begin
            valid_o = (ver_i != 4'd0) && (num_i <= lim);
            set_o   = SET_EXT;
            idx_o   = num_i - EXT_BASE;
            impl_o  = (idx_o < 8'(EXT_N));
        end
    end
endmodule

// File: rtl/evt_ctr_facility.sv
module evt_ctr_facility
    import efc_pkg::*;
#(
    parameter int CTR_W = 64,
    parameter int EXT_N = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             user_mode_i,
    input  logic [5:0]       ev_basic_i,
    input  logic [5:0]       ev_user_i,
    input  logic [15:0]      ev_crypto_i,
    input  logic [EXT_N-1:0] ev_ext_i,
    input  logic [3:0]       auth_i,
    input  logic [3:0]       set_ver_i,
    input  logic             ctl_wr_i,
    input  logic [31:0]      ctl_wdata_i,
    output logic [31:0]      ctl_word_o,
    input  logic             rd_req_i,
    input  logic [7:0]       rd_num_i,
    output logic             rd_valid_o,
    output logic [1:0]       rd_err_o,
    output logic [CTR_W-1:0] rd_data_o,
    output logic             alert_auth_o,
    output logic             alert_lost_o
);
    localparam int EXT_IW = (EXT_N > 1) ? $clog2(EXT_N) : 1;

    typedef struct packed {
        logic             valid;
        logic [1:0]       err;
        logic [CTR_W-1:0] data;
    } rd_st_t;

    logic [NSETS-1:0] en_q, act_q, en_d, run;
    logic [BASIC_N-1:0][CTR_W-1:0]  cnt_basic;
    logic [USER_N-1:0][CTR_W-1:0]   cnt_user;
    logic [CRYPTO_N-1:0][CTR_W-1:0] cnt_crypto;
    logic [EXT_N-1:0][CTR_W-1:0]    cnt_ext;

    logic       dec_valid, dec_impl;
    set_e       dec_set;
    logic [7:0] dec_idx;
    rd_st_t     rd_d, rd_q;
    logic       unused_bits;

    efc_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .auth_i       (auth_i),
        .wr_i         (ctl_wr_i),
        .wr_en_bits_i (ctl_wdata_i[EN_LSB +: NSETS]),
        .wr_act_bits_i(ctl_wdata_i[ACT_LSB +: NSETS]),
        .en_q_o       (en_q),
        .act_q_o      (act_q),
        .en_d_o       (en_d),
        .alert_auth_o (alert_auth_o),
        .alert_lost_o (alert_lost_o)
    );

    always_comb begin
        run           = en_q & act_q;
        run[SET_USER] = en_q[SET_USER] & act_q[SET_USER] & user_mode_i;
    end

    efc_set_bank #(.N(BASIC_N), .W(CTR_W)) u_basic (
        .clk(clk), .rst_n(rst_n), .keep_i(en_d[SET_BASIC]), .run_i(run[SET_BASIC]),
        .ev_i(ev_basic_i), .cnt_o(cnt_basic));

    efc_set_bank #(.N(USER_N), .W(CTR_W)) u_user (
        .clk(clk), .rst_n(rst_n), .keep_i(en_d[SET_USER]), .run_i(run[SET_USER]),
        .ev_i(ev_user_i), .cnt_o(cnt_user));

    efc_set_bank #(.N(CRYPTO_N), .W(CTR_W)) u_crypto (
        .clk(clk), .rst_n(rst_n), .keep_i(en_d[SET_CRYPTO]), .run_i(run[SET_CRYPTO]),
        .ev_i(ev_crypto_i), .cnt_o(cnt_crypto));

    efc_set_bank #(.N(EXT_N), .W(CTR_W)) u_ext (
        .clk(clk), .rst_n(rst_n), .keep_i(en_d[SET_EXT]), .run_i(run[SET_EXT]),
        .ev_i(ev_ext_i), .cnt_o(cnt_ext));

    efc_num_decode #(.EXT_N(EXT_N)) u_dec (
        .num_i  (rd_num_i),
        .ver_i  (set_ver_i),
        .valid_o(dec_valid),
        .set_o  (dec_set),
        .idx_o  (dec_idx),
        .impl_o (dec_impl)
    );

    always_comb begin
        rd_d = '0;
        if (rd_req_i) begin
            rd_d.valid = 1'b1;
            if (!dec_valid) begin
                rd_d.err = RD_INVALID;
            end else if (!en_q[dec_set]) begin
                rd_d.err = RD_UNAVAIL;
            end else if (dec_impl) begin
                unique case (dec_set)
                    SET_BASIC:  rd_d.data = cnt_basic[dec_idx[BASIC_IW-1:0]];
                    SET_USER:   rd_d.data = cnt_user[dec_idx[USER_IW-1:0]];
                    SET_CRYPTO: rd_d.data = cnt_crypto[dec_idx[CRYPTO_IW-1:0]];
                    default:    rd_d.data = cnt_ext[dec_idx[EXT_IW-1:0]];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    always_comb begin
        ctl_word_o                     = '0;
        ctl_word_o[EN_LSB +: NSETS]    = en_q;
        ctl_word_o[ACT_LSB +: NSETS]   = act_q;
    end

    assign rd_valid_o  = rd_q.valid;
    assign rd_err_o    = rd_q.err;
    assign rd_data_o   = rd_q.data;
    assign unused_bits = ^{dec_idx, ctl_wdata_i[31:20], ctl_wdata_i[15:4]};

    // R11
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> rd_valid_o);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_i |=> (!rd_valid_o && rd_err_o == 2'd0 && rd_data_o == '0));

    // R11
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_err_o != 2'd0) |-> (rd_data_o == '0));

    // R1
    ctl_spare_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctl_word_o & 32'hFFF0_FFF0) == 32'h0));
endmodule

// File: tb/evt_ctr_facility_test.sv
module evt_ctr_facility_test;
    localparam int W     = 8;
    localparam int EXT_N = 48;
    localparam longint unsigned MASK = (64'd1 << W) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             user_mode = 1'b0;
    logic [5:0]       ev_basic = '0;
    logic [5:0]       ev_user = '0;
    logic [15:0]      ev_crypto = '0;
    logic [EXT_N-1:0] ev_ext = '0;
    logic [3:0]       auth = '0;
    logic [3:0]       ver = 4'd1;
    logic             ctl_wr = 1'b0;
    logic [31:0]      ctl_wdata = '0;
    logic [31:0]      ctl_word;
    logic             rd_req = 1'b0;
    logic [7:0]       rd_num = '0;
    logic             rd_valid;
    logic [1:0]       rd_err;
    logic [W-1:0]     rd_data;
    logic             alert_auth, alert_lost;

    evt_ctr_facility #(.CTR_W(W), .EXT_N(EXT_N)) uut (
        .clk(clk), .rst_n(rst_n), .user_mode_i(user_mode),
        .ev_basic_i(ev_basic), .ev_user_i(ev_user), .ev_crypto_i(ev_crypto), .ev_ext_i(ev_ext),
        .auth_i(auth), .set_ver_i(ver), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
        .ctl_word_o(ctl_word), .rd_req_i(rd_req), .rd_num_i(rd_num),
        .rd_valid_o(rd_valid), .rd_err_o(rd_err), .rd_data_o(rd_data),
        .alert_auth_o(alert_auth), .alert_lost_o(alert_lost));

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R12";
    longint unsigned m_cnt [256];
    int unsigned m_ctl = 0;
    logic [3:0] m_auth_prev = '0;
    logic [63:0] rng = 64'h1234_5678_9abc_def1;
    int rd_list[$];
    int rd_pos = 0;
    bit hold_ev = 0;
    bit rd_gap = 0;

    task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s (phase %s) actual=%0h expected=%0h", req, what, tag, act, exp);
        end
    endtask

    function automatic int set_of(int n);
        if (n < 32) return 1;
        if (n < 64) return 2;
        if (n < 128) return 3;
        return 0;
    endfunction

    function automatic bit built(int n);
        return (n < 6) || (n >= 32 && n < 38) || (n >= 64 && n < 80) ||
               (n >= 128 && n < 128 + EXT_N);
    endfunction

    function automatic bit num_ok(int n, int v);
        int lim;
        lim = (v == 1) ? 159 : (v == 2) ? 175 : 255;
        if (n < 6 || (n >= 32 && n < 38)) return 1;
        if (n >= 64 && n < 80) return v != 0;
        if (n >= 128) return (v != 0) && (n <= lim);
        return 0;
    endfunction

    function automatic bit ev_of(int n);
        if (n < 6) return ev_basic[n];
        if (n >= 32 && n < 38) return ev_user[n-32];
        if (n >= 64 && n < 80) return ev_crypto[n-64];
        if (n >= 128 && n < 128 + EXT_N) return ev_ext[n-128];
        return 0;
    endfunction

    task automatic step();
        int unauth, req_en, s;
        bit accept, e_auth, e_lost, e_valid;
        int unsigned new_ctl;
        int e_err;
        longint unsigned e_data;
        unauth  = int'(~auth) & 4'hF;
        req_en  = int'(ctl_wdata[19:16]);
        accept  = ctl_wr && ((req_en & unauth) == 0);
        new_ctl = accept ? (ctl_wdata & 32'h000F_000F) : m_ctl;
        new_ctl = new_ctl & ~((unauth << 16) | unauth);
        e_lost  = (((m_ctl >> 16) & 4'hF) & unauth) != 0;
        e_auth  = (auth != m_auth_prev);
        e_valid = rd_req;
        e_err   = 0;
        e_data  = 0;
        if (rd_req) begin
            if (!num_ok(int'(rd_num), int'(ver))) e_err = 1;
            else if (((m_ctl >> (16 + set_of(int'(rd_num)))) & 1) == 0) e_err = 2;
            else e_data = m_cnt[rd_num];
        end
        @(posedge clk);
        #1;
        for (int n = 0; n < 256; n++) begin
            if (built(n)) begin
                s = set_of(n);
                if (((new_ctl >> (16 + s)) & 1) == 0) m_cnt[n] = 0;
                else if ((((m_ctl >> (16 + s)) & 1) == 1) && (((m_ctl >> s) & 1) == 1) &&
                         ev_of(n) && (s != 2 || user_mode))
                    m_cnt[n] = (m_cnt[n] + 1) & MASK;
            end
        end
        m_ctl = new_ctl;
        m_auth_prev = auth;
        chk("R1", "ctl_word", ctl_word, m_ctl);
        chk("R10", "alert_auth", alert_auth, e_auth);
        chk("R9", "alert_lost", alert_lost, e_lost);
        chk("R11", "rd_valid", rd_valid, e_valid);
        chk("R11", "rd_err", rd_err, e_err);
        chk("R11", "rd_data", rd_data, e_data);
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 7);
            rng = rng ^ (rng << 17);
            if (hold_ev) begin
                ev_basic = '1; ev_user = '1; ev_crypto = '1; ev_ext = '1;
            end else begin
                ev_basic = rng[5:0]; ev_user = rng[11:6];
                ev_crypto = rng[27:12]; ev_ext = rng[63:16];
            end
            user_mode = rng[3] ^ rng[40];
            if (rd_list.size() > 0 && (!rd_gap || rng[7])) begin
                rd_req = 1'b1;
                rd_num = 8'(rd_list[rd_pos % rd_list.size()]);
                rd_pos++;
            end else begin
                rd_req = 1'b0;
                rd_num = 8'(rng[15:8]);
            end
            step();
        end
    endtask

    task automatic wr(int unsigned val);
        ctl_wr = 1'b1;
        ctl_wdata = val;
        run(1);
        ctl_wr = 1'b0;
        ctl_wdata = '0;
    endtask

    initial begin
        for (int n = 0; n < 256; n++) m_cnt[n] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        chk("R12", "ctl_word", ctl_word, 0);
        chk("R12", "alert_auth", alert_auth, 0);
        chk("R12", "alert_lost", alert_lost, 0);
        chk("R12", "rd_valid", rd_valid, 0);
        chk("R12", "rd_data", rd_data, 0);
        run(2);

        tag = "R10";
        auth = 4'hF;
        run(3);

        tag = "R1";
        rd_list = '{0, 1, 5, 32, 33, 37};
        wr(32'h000F_0006);
        run(4);

        tag = "R4_R5";
        run(60);
        rd_gap = 1;
        tag = "R11";
        run(30);
        rd_gap = 0;

        tag = "R3";
        wr(32'h000F_0000);
        run(30);

        tag = "R2";
        wr(32'h000D_0002);
        run(10);
        wr(32'h000F_0002);
        run(20);

        tag = "R6";
        rd_list = '{6, 31, 38, 63, 80, 127, 5, 37};
        run(8);

        tag = "R7";
        wr(32'h000F_000F);
        rd_list = '{64, 79, 128, 159, 160, 175, 176, 255, 130};
        for (int v = 0; v < 4; v++) begin
            ver = 4'(v);
            run(18);
        end
        ver = 4'd1;

        tag = "R9";
        rd_list = '{64, 70, 0, 130};
        auth = 4'h7;
        run(6);

        tag = "R8";
        wr(32'h000F_000F);
        run(4);
        wr(32'h0007_0007);
        run(6);

        tag = "R4_wrap";
        auth = 4'hF;
        wr(32'h0001_0001);
        hold_ev = 1;
        rd_list = '{130, 175, 0};
        run(300);
        hold_ev = 0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule